// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the receive front end of an I2C target device. It watches the SCL and SDA lines, which arrive already synchronized to the system clock. It finds START and STOP conditions and counts the bit times of each byte, including its acknowledge slot. The first byte after every START or repeated START is compared against four programmable 7-bit addresses, and each of those addresses carries its own don't-care mask. An all-zero address is the general call. It is accepted by any slot whose general-call enable is set, and the masks play no part in that decision. On an accepted byte the block pulls SDA low for the acknowledge bit, raises the interrupt flag and reports which slot matched.

Software reaches the block through one narrow write port. Through it, software loads the address and mask registers, sets control bits with write-one-to-set and clears them with write-one-to-clear. Every byte that passes on the bus after a START is copied into a snoop buffer at its ninth clock, whether or not this device was addressed.

The control sequencer has six states. IDLE waits for a START. ADDR shifts in the address byte. ADDR_ACK holds the acknowledge of a matched address. DATA shifts in a written data byte. DATA_ACK holds the acknowledge of a data byte. SKIP lets bits pass without any response until the next START or STOP.

The transitions are as follows. A START moves any state to ADDR, and a STOP moves any state to IDLE. ADDR goes to ADDR_ACK on a match, and to SKIP otherwise, at the 8th rising edge of SCL. At the 9th rising edge, ADDR_ACK goes to DATA for a write or to SKIP for a read. DATA goes to DATA_ACK at the 8th rising edge when assert-acknowledge is set, and to SKIP when it is clear. DATA_ACK returns to DATA at the 9th rising edge.

Top module: `i2c_am`

## Requirements
- R1: After reset, ctrl_o, data_buf_o, match_slot_o, gen_call_o, ack_drive_o and addressed_o are all zero, and every address, mask and general-call enable register is zero.
- R2: A START (SDA falls while SCL stays high) starts an address byte from any state. A STOP (SDA rises while SCL stays high) returns to idle and drops ack_drive_o and addressed_o. addressed_o is high from an accepted address until the transfer is released.
- R3: The address byte is the first byte after a START, sent MSB first: bits 7:1 are the address and bit 0 is read/write (1 = read). Slot s hits when ((rx XOR addr_s) AND NOT mask_s) is zero, and a mask bit of 1 makes that address bit don't-care. When several slots hit, the lowest slot index is reported on match_slot_o.
- R4: A received address of 0000000 is a general call. It hits exactly those slots whose general-call enable is 1, whatever their masks hold, and gen_call_o goes high when it is accepted.
- R5: An address is accepted only when control bit 6 (enable) and bit 2 (assert-acknowledge) are both 1 at its 8th SCL rising edge. ack_drive_o rises at the SCL falling edge after the 8th bit and falls at the SCL falling edge after the 9th bit. A rejected address gets no acknowledge.
- R6: After an accepted write address, each data byte is acknowledged if assert-acknowledge is 1 at its 8th rising edge. A byte sent with it clear is not acknowledged, and no later byte is acknowledged until the next START.
- R7: At the 9th SCL rising edge of every byte after a START, data_buf_o takes that byte's 8 data bits, whether or not the device was addressed. While idle it holds.
- R8: Control bit 3 (interrupt flag) is set at the 9th SCL rising edge of every acknowledged byte. This set beats a software clear made in the same cycle.
- R9: A write to select 0 sets each control bit whose write-data bit is 1. A write to select 1 clears each control bit whose write-data bit is 1. Zero bits are left alone. Bits 4 and 5 are plain flags, and bits 0, 1 and 7 always read 0.
- R10: Select 2+s loads slot s with the address in write-data bits 7:1 and the general-call enable in bit 0. Select 2+NUM_SLOTS+s loads slot s's mask from write-data bits 7:1.
- R11: After an accepted read address (bit 0 = 1), the address is acknowledged, and the bytes that follow are not acknowledged and leave addressed_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized SCL line |
| sda_i | input | 1 | Synchronized SDA line |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | $clog2(2+2*NUM_SLOTS) | Register select (0 set, 1 clear, then addresses, then masks) |
| reg_wdata_i | input | 8 | Register write data |
| ctrl_o | output | 8 | Control bits (2 ack enable, 3 interrupt, 4 stop flag, 5 start flag, 6 enable) |
| data_buf_o | output | 8 | Snoop buffer holding the last byte seen on the bus |
| ack_drive_o | output | 1 | Pull SDA low (acknowledge) |
| addressed_o | output | 1 | Device currently selected for a transfer |
| match_slot_o | output | $clog2(NUM_SLOTS) | Index of the slot that accepted the last address |
| gen_call_o | output | 1 | Last accepted address was a general call |

## Verification
The bench builds the block with its default four slots and 7-bit addresses. With four slots it can program overlapping slots, where a masked slot and an exact slot both hit, and so check that the lowest index wins. It can also leave one slot fully masked, so that a general call with no enables set shows the masks are bypassed. The bus is modelled as open drain, so the block's own acknowledge appears on SDA the way a controller would see it. A same-cycle interrupt-flag set and clear is timed exactly at the 9th rising edge.

// File: rtl/i2c_am_pkg.sv
`timescale 1ns/1ps
package i2c_am_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } am_state_e;

    // control bit positions (software visible)
    localparam int CTL_AA  = 2;
    localparam int CTL_SI  = 3;
    localparam int CTL_STO = 4;
    localparam int CTL_STA = 5;
    localparam int CTL_EN  = 6;

    localparam logic [7:0] CTL_IMPL = (8'(1) << CTL_AA) | (8'(1) << CTL_SI) |
                                      (8'(1) << CTL_STO) | (8'(1) << CTL_STA) |
                                      (8'(1) << CTL_EN);

    // register select map
    localparam int SEL_SET   = 0;
    localparam int SEL_CLR   = 1;
    localparam int SEL_ADDR0 = 2;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2c_am_busev.sv
`timescale 1ns/1ps
module i2c_am_busev (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_d;
    logic sda_d;

    // idle bus is high on both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_d;
    assign scl_fall_o = ~scl_i & scl_d;
    assign start_o    = scl_i & scl_d & sda_d & ~sda_i;
    assign stop_o     = scl_i & scl_d & ~sda_d & sda_i;

endmodule

// File: rtl/i2c_am_regs.sv
`timescale 1ns/1ps
module i2c_am_regs
    import i2c_am_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 7,
    parameter int SEL_W     = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we_i,
    input  logic [SEL_W-1:0]                   sel_i,
    input  logic [7:0]                         wdata_i,
    input  logic                               si_set_i,
    output logic [7:0]                         ctrl_o,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   addr_o,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   mask_o,
    output logic [NUM_SLOTS-1:0]               gcen_o
);

    logic [7:0] ctrl_q;
    logic [7:0] set_v;
    logic [7:0] clr_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (we_i && sel_i == SEL_W'(SEL_SET)) set_v = wdata_i & CTL_IMPL;
        if (we_i && sel_i == SEL_W'(SEL_CLR)) clr_v = wdata_i & CTL_IMPL;
        if (si_set_i)                         set_v[CTL_SI] = 1'b1;
    end

    // set takes priority over clear on the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= (ctrl_q & ~clr_v) | set_v;
    end

    assign ctrl_o = ctrl_q;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            localparam int ASEL = SEL_ADDR0 + s;
            localparam int MSEL = SEL_ADDR0 + NUM_SLOTS + s;
            logic [ADDR_W-1:0] a_q;
            logic [ADDR_W-1:0] m_q;
            logic              g_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    a_q <= '0;
                    g_q <= 1'b0;
                end else if (we_i && sel_i == SEL_W'(ASEL)) begin
                    a_q <= wdata_i[ADDR_W:1];
                    g_q <= wdata_i[0];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n)                                m_q <= '0;
                else if (we_i && sel_i == SEL_W'(MSEL))    m_q <= wdata_i[ADDR_W:1];
            end

            assign addr_o[s] = a_q;
            assign mask_o[s] = m_q;
            assign gcen_o[s] = g_q;
        end
    endgenerate

    AST_SI_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        si_set_i |=> ctrl_q[CTL_SI]); // R8

    AST_CLR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_W'(SEL_CLR) && wdata_i[CTL_EN]) |=> !ctrl_q[CTL_EN]); // R9

endmodule

// File: rtl/i2c_am_cmp.sv
`timescale 1ns/1ps
module i2c_am_cmp #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 7,
    parameter int IDX_W     = 2
) (
    input  logic [ADDR_W-1:0]                  rx_addr_i,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]   addr_i,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]   mask_i,
    input  logic [NUM_SLOTS-1:0]               gcen_i,
    output logic                               hit_o,
    output logic [IDX_W-1:0]                   idx_o,
    output logic                               gc_o
);

    logic [NUM_SLOTS-1:0] hit_v;
    logic                 is_gc;

    assign is_gc = (rx_addr_i == '0);

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
            // masks are bypassed for the all-zero address
            assign hit_v[s] = is_gc ? gcen_i[s]
                                    : (((rx_addr_i ^ addr_i[s]) & ~mask_i[s]) == '0);
        end
    endgenerate

    // lowest index wins
    always_comb begin
        idx_o = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (hit_v[s]) idx_o = IDX_W'(s);
        end
    end

    assign hit_o = |hit_v;
    assign gc_o  = is_gc;

endmodule

// File: rtl/i2c_am.sv
`timescale 1ns/1ps
module i2c_am
    import i2c_am_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 7
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 scl_i,
    input  logic                                 sda_i,
    input  logic                                 reg_we_i,
    input  logic [$clog2(2+2*NUM_SLOTS)-1:0]     reg_sel_i,
    input  logic [7:0]                           reg_wdata_i,
    output logic [7:0]                           ctrl_o,
    output logic [7:0]                           data_buf_o,
    output logic                                 ack_drive_o,
    output logic                                 addressed_o,
    output logic [$clog2(NUM_SLOTS)-1:0]         match_slot_o,
    output logic                                 gen_call_o
);

    localparam int SEL_W = $clog2(2 + 2*NUM_SLOTS);
    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    logic scl_rise, scl_fall, start_ev, stop_ev;

    i2c_am_busev u_busev (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    logic [7:0]                         ctrl_q;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0]   slot_addr;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0]   slot_mask;
    logic [NUM_SLOTS-1:0]               slot_gcen;
    logic                               si_set;

    i2c_am_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we_i),
        .sel_i    (reg_sel_i),
        .wdata_i  (reg_wdata_i),
        .si_set_i (si_set),
        .ctrl_o   (ctrl_q),
        .addr_o   (slot_addr),
        .mask_o   (slot_mask),
        .gcen_o   (slot_gcen)
    );

    am_state_e             state_q, state_d;
    logic [CNT_W-1:0]      bitcnt_q;
    logic [BYTE_BITS-1:0]  shift_q;
    logic [BYTE_BITS-1:0]  rx_byte;
    logic [BYTE_BITS-1:0]  data_buf_q;
    logic                  ack_q;
    logic                  rw_q;
    logic [IDX_W-1:0]      slot_q;
    logic                  gc_q;
    logic                  bit8, bit9;
    logic                  cmp_hit, cmp_gc;
    logic [IDX_W-1:0]      cmp_idx;
    logic                  take_match;

    assign rx_byte = {shift_q[BYTE_BITS-2:0], sda_i};
    assign bit8    = scl_rise && (bitcnt_q == CNT_W'(BYTE_BITS - 1));
    assign bit9    = scl_rise && (bitcnt_q == CNT_W'(BYTE_BITS));

    i2c_am_cmp #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) u_cmp (
        .rx_addr_i (rx_byte[ADDR_W:1]),
        .addr_i    (slot_addr),
        .mask_i    (slot_mask),
        .gcen_i    (slot_gcen),
        .hit_o     (cmp_hit),
        .idx_o     (cmp_idx),
        .gc_o      (cmp_gc)
    );

    // next-state logic
    always_comb begin
        state_d    = state_q;
        si_set     = 1'b0;
        take_match = 1'b0;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (bit8) begin
                        if (ctrl_q[CTL_EN] && ctrl_q[CTL_AA] && cmp_hit) begin
                            state_d    = ST_ADDR_ACK;
                            take_match = 1'b1;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (bit9) begin
                        state_d = rw_q ? ST_SKIP : ST_DATA;
                        si_set  = 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit8) state_d = ctrl_q[CTL_AA] ? ST_DATA_ACK : ST_SKIP;
                end
                ST_DATA_ACK: begin
                    if (bit9) begin
                        state_d = ST_DATA;
                        si_set  = 1'b1;
                    end
                end
                ST_SKIP: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit counter, shifter and snoop buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            shift_q    <= '0;
            data_buf_q <= '0;
        end else if (start_ev || stop_ev) begin
            bitcnt_q <= '0;
        end else if (scl_rise && state_q != ST_IDLE) begin
            if (bitcnt_q == CNT_W'(BYTE_BITS)) begin
                bitcnt_q   <= '0;
                data_buf_q <= shift_q;
            end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
                shift_q  <= rx_byte;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            rw_q   <= 1'b0;
            slot_q <= '0;
            gc_q   <= 1'b0;
        end else begin
            if (start_ev || stop_ev) begin
                ack_q <= 1'b0;
            end else if (scl_fall) begin
                ack_q <= (state_q == ST_ADDR_ACK) || (state_q == ST_DATA_ACK);
            end
            if (take_match) begin
                slot_q <= cmp_idx;
                gc_q   <= cmp_gc;
                rw_q   <= rx_byte[0];
            end
        end
    end

    assign ctrl_o       = ctrl_q;
    assign data_buf_o   = data_buf_q;
    assign ack_drive_o  = ack_q;
    assign match_slot_o = slot_q;
    assign gen_call_o   = gc_q;
    assign addressed_o  = (state_q == ST_ADDR_ACK) || (state_q == ST_DATA) ||
                          (state_q == ST_DATA_ACK);

    AST_ACK_IN_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive_o |-> (state_q != ST_IDLE)); // R2

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drive_o) |-> !$past(scl_i)); // R5

    AST_ADDR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addressed_o) |-> $past(ctrl_o[CTL_EN] && ctrl_o[CTL_AA])); // R5

    AST_IDLE_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(data_buf_o)); // R7

endmodule

// File: tb/i2c_am_tb_top.sv
`timescale 1ns/1ps
module i2c_am_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_w = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_bus;
    logic       reg_we = 1'b0;
    logic [3:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] ctrl_o, data_buf_o;
    logic       ack_drive_o, addressed_o, gen_call_o;
    logic [1:0] match_slot_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit run_cmp = 0;

    always #4 clk = ~clk;

    assign sda_bus = sda_drv & ~ack_drive_o;

    i2c_am dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_w),
        .sda_i        (sda_bus),
        .reg_we_i     (reg_we),
        .reg_sel_i    (reg_sel),
        .reg_wdata_i  (reg_wdata),
        .ctrl_o       (ctrl_o),
        .data_buf_o   (data_buf_o),
        .ack_drive_o  (ack_drive_o),
        .addressed_o  (addressed_o),
        .match_slot_o (match_slot_o),
        .gen_call_o   (gen_call_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_ph;            // 0 idle 1 addr 2 addr-ack 3 data 4 data-ack 5 skip
    bit          m_pscl, m_psda;
    bit          m_q[$];
    logic [7:0]  m_ctrl, m_buf, m_byte, m_set, m_clr;
    bit          m_ack, m_gc, m_rw, m_si;
    int          m_slot, m_found;
    logic [6:0]  m_addr[4];
    logic [6:0]  m_mask[4];
    bit          m_gcen[4];
    bit          e_rise, e_fall, e_st, e_sp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pscl = 1; m_psda = 1; m_q.delete();
            m_ctrl = 0; m_buf = 0; m_ack = 0; m_gc = 0; m_rw = 0; m_slot = 0;
            for (int i = 0; i < 4; i++) begin
                m_addr[i] = 0; m_mask[i] = 0; m_gcen[i] = 0;
            end
        end else begin
            e_rise = scl_w && !m_pscl;
            e_fall = !scl_w && m_pscl;
            e_st   = scl_w && m_pscl && m_psda && !sda_bus;
            e_sp   = scl_w && m_pscl && !m_psda && sda_bus;
            m_si   = 0;
            if (e_st) begin
                m_ph = 1; m_q.delete(); m_ack = 0;
            end else if (e_sp) begin
                m_ph = 0; m_q.delete(); m_ack = 0;
            end else begin
                if (e_fall) m_ack = (m_ph == 2) || (m_ph == 4);
                if (e_rise && m_ph != 0) begin
                    m_q.push_back(sda_bus);
                    if (m_q.size() == 8) begin
                        m_byte = 0;
                        for (int i = 0; i < 8; i++) m_byte = {m_byte[6:0], m_q[i]};
                        if (m_ph == 1) begin
                            m_found = -1;
                            if (m_ctrl[6] && m_ctrl[2]) begin
                                for (int i = 0; i < 4; i++) begin
                                    if (m_found < 0) begin
                                        if (m_byte[7:1] == 0) begin
                                            if (m_gcen[i]) m_found = i;
                                        end else if (((m_byte[7:1] ^ m_addr[i]) & ~m_mask[i]) == 0) begin
                                            m_found = i;
                                        end
                                    end
                                end
                            end
                            if (m_found >= 0) begin
                                m_ph = 2; m_slot = m_found;
                                m_gc = (m_byte[7:1] == 0); m_rw = m_byte[0];
                            end else begin
                                m_ph = 5;
                            end
                        end else if (m_ph == 3) begin
                            m_ph = m_ctrl[2] ? 4 : 5;
                        end
                    end else if (m_q.size() == 9) begin
                        m_byte = 0;
                        for (int i = 0; i < 8; i++) m_byte = {m_byte[6:0], m_q[i]};
                        m_buf = m_byte;
                        if (m_ph == 2) begin
                            m_si = 1; m_ph = m_rw ? 5 : 3;
                        end else if (m_ph == 4) begin
                            m_si = 1; m_ph = 3;
                        end
                        m_q.delete();
                    end
                end
            end
            m_set = 0; m_clr = 0;
            if (reg_we && reg_sel == 0) m_set = reg_wdata & 8'h7C;
            if (reg_we && reg_sel == 1) m_clr = reg_wdata & 8'h7C;
            m_ctrl = (m_ctrl & ~m_clr) | m_set | (m_si ? 8'h08 : 8'h00);
            if (reg_we && reg_sel >= 2 && reg_sel <= 5) begin
                m_addr[reg_sel - 2] = reg_wdata[7:1];
                m_gcen[reg_sel - 2] = reg_wdata[0];
            end
            if (reg_we && reg_sel >= 6 && reg_sel <= 9) m_mask[reg_sel - 6] = reg_wdata[7:1];
            m_pscl = scl_w;
            m_psda = sda_bus;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk("R5 ack_drive", ack_drive_o, m_ack);
            chk("R7 data_buf", data_buf_o, m_buf);
            chk("R9 ctrl", ctrl_o, m_ctrl);
            chk("R2 addressed", addressed_o, (m_ph >= 2 && m_ph <= 4));
            chk("R3 match_slot", match_slot_o, m_slot);
            chk("R4 gen_call", gen_call_o, m_gc);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] d);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        tick(1);
        reg_we = 0;
        tick(1);
    endtask

    task automatic bus_start();
        sda_drv = 1; tick(2);
        scl_w = 1;   tick(3);
        sda_drv = 0; tick(3);
        scl_w = 0;   tick(2);
    endtask

    task automatic bus_stop();
        sda_drv = 0; tick(2);
        scl_w = 1;   tick(3);
        sda_drv = 1; tick(3);
    endtask

    task automatic bus_bit(input bit b, output bit seen);
        sda_drv = b; tick(2);
        scl_w = 1;   tick(2);
        seen = sda_bus; tick(1);
        scl_w = 0;   tick(2);
    endtask

    task automatic bus_byte(input logic [7:0] v, input bit clr_si_at_9th, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
        sda_drv = 1; tick(2);
        scl_w = 1;
        if (clr_si_at_9th) begin
            reg_we = 1; reg_sel = 1; reg_wdata = 8'h08;
        end
        tick(1);
        reg_we = 0;
        tick(1);
        s = sda_bus; tick(1);
        scl_w = 0; tick(2);
        acked = !s;
    endtask

    initial begin : main
        bit a;
        tick(4);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1 ctrl", ctrl_o, 0);
        chk("R1 data_buf", data_buf_o, 0);
        chk("R1 ack", ack_drive_o, 0);
        chk("R1 addressed", addressed_o, 0);
        chk("R1 slot", match_slot_o, 0);
        chk("R1 gen_call", gen_call_o, 0);
        run_cmp = 1;

        // R10 program slots
        wr(2, {7'h50, 1'b0});
        wr(3, {7'h20, 1'b1});
        wr(7, {7'h0F, 1'b0});
        wr(4, {7'h21, 1'b0});
        wr(5, {7'h7F, 1'b0});
        wr(0, 8'hFF);
        chk("R9 set masks reserved bits", ctrl_o, 8'h7C);
        wr(1, 8'h38);
        chk("R9 clear", ctrl_o, 8'h44);

        // R3 exact slot 0 write
        bus_start();
        bus_byte({7'h50, 1'b0}, 0, a);
        chk("R3 addr acked", a, 1);
        chk("R3 slot0", match_slot_o, 0);
        chk("R2 addressed", addressed_o, 1);
        bus_byte(8'hA5, 0, a);
        chk("R6 data acked", a, 1);
        chk("R7 buffer", data_buf_o, 8'hA5);
        chk("R8 SI", ctrl_o[3], 1);
        bus_stop();
        chk("R2 stop releases", addressed_o, 0);
        wr(1, 8'h08);
        chk("R9 SI cleared", ctrl_o, 8'h44);

        // R3 masked slot, and priority on repeated start
        bus_start();
        bus_byte({7'h2B, 1'b0}, 0, a);
        chk("R3 masked acked", a, 1);
        chk("R3 slot1", match_slot_o, 1);
        bus_start();
        bus_byte({7'h21, 1'b0}, 0, a);
        chk("R3 priority acked", a, 1);
        chk("R3 lowest index", match_slot_o, 1);
        bus_stop();

        // R5 no match, R7 snoop
        bus_start();
        bus_byte({7'h33, 1'b0}, 0, a);
        chk("R5 no match nack", a, 0);
        bus_byte(8'h3C, 0, a);
        chk("R7 snoop no ack", a, 0);
        chk("R7 snoop buffer", data_buf_o, 8'h3C);
        chk("R5 not addressed", addressed_o, 0);
        bus_stop();

        // R4 general call through slot 1 enable
        bus_start();
        bus_byte(8'h00, 0, a);
        chk("R4 gc acked", a, 1);
        chk("R4 gen_call_o", gen_call_o, 1);
        chk("R4 gc slot", match_slot_o, 1);
        bus_stop();

        // R4 masks ignored for general call
        wr(3, {7'h20, 1'b0});
        wr(9, {7'h7F, 1'b0});
        bus_start();
        bus_byte(8'h00, 0, a);
        chk("R4 gc without enable nack", a, 0);
        bus_start();
        bus_byte({7'h55, 1'b0}, 0, a);
        chk("R3 full mask acked", a, 1);
        chk("R3 slot3", match_slot_o, 3);
        chk("R4 gen_call clear", gen_call_o, 0);
        bus_stop();

        // R5 AA clear, then EN clear
        wr(1, 8'h04);
        bus_start();
        bus_byte({7'h50, 1'b0}, 0, a);
        chk("R5 AA clear nack", a, 0);
        bus_stop();
        wr(0, 8'h04);
        wr(1, 8'h40);
        bus_start();
        bus_byte({7'h50, 1'b0}, 0, a);
        chk("R5 EN clear nack", a, 0);
        bus_stop();
        wr(0, 8'h40);

        // R6 data NACK then ignore
        bus_start();
        bus_byte({7'h50, 1'b0}, 0, a);
        chk("R6 addr acked", a, 1);
        wr(1, 8'h04);
        bus_byte(8'h11, 0, a);
        chk("R6 data nack", a, 0);
        wr(0, 8'h04);
        bus_byte(8'h22, 0, a);
        chk("R6 stays ignored", a, 0);
        chk("R7 buffer after nack", data_buf_o, 8'h22);
        bus_stop();

        // R11 read address
        bus_start();
        bus_byte({7'h50, 1'b1}, 0, a);
        chk("R11 read addr acked", a, 1);
        chk("R11 read not addressed", addressed_o, 0);
        bus_byte(8'hFF, 0, a);
        chk("R11 read data no ack", a, 0);
        bus_stop();

        // R8 hardware set beats same-cycle clear
        wr(1, 8'h08);
        bus_start();
        bus_byte({7'h50, 1'b0}, 1, a);
        chk("R8 set wins over clear", ctrl_o[3], 1);
        bus_stop();

        tick(4);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule